// File: doc/BRIEF.md
# Three-Wire Synthesizer Programming Port

This block is the serial loading port of a frequency synthesizer control core. A host drives three lines: a serial clock, a serial data line and a latch enable. Words of 20 bits are shifted in most significant bit first while latch enable is low. A rising latch enable moves the word into one of three holding registers. The two bits shifted in last pick the register. The registers hold the feedback divider value, the reference divider value with its three test bits, and the standby and switch-output bits. Their contents drive the divider and control logic downstream.

All logic runs on one system clock. The three serial lines are assumed to be synchronous to that clock already, and each of them is held for at least one system clock between changes. Edges of the serial clock and the latch enable are found by comparing each line with its value one cycle earlier. A serial clock rise shifts the register on the same system clock edge that samples it. A latch enable rise updates the chosen register on the same edge, so the new value is seen at the outputs after that edge.

Top module: `synth_prog_port`

## Requirements
- R1: After a synchronous active-low reset, feedback main count, swallow count, reference count, standby and switch output read zero, and test_bits reads 3'b100.
- R2: Each rising edge of ser_clk seen while ser_le is low shifts ser_dat into the word. The first bit sent ends up as word bit 19. When more than 20 bits are sent, only the 20 most recent ones are used.
- R3: While ser_le is high, rising edges of ser_clk do not change the word. A later latch enable rise with no shifting in between transfers the unchanged word again.
- R4: On a rising ser_le with word bit 0 equal to 0, whatever the value of word bit 1, fb_main takes word bits 19..8 and fb_swallow takes word bits 7..2.
- R5: On a rising ser_le with word bits 1..0 equal to 2'b11, word bits 19..18 are discarded, ref_count takes word bits 17..5, and test_bits takes word bits 4..2. test_bits[2] (R14) is word bit 4, test_bits[1] (R15) is word bit 3 and test_bits[0] (R16) is word bit 2.
- R6: On a rising ser_le with word bits 1..0 equal to 2'b01, standby takes word bit 19 and switch_out takes word bit 18. Word bits 17..2 are unused.
- R7: A holding register keeps its contents through transfers aimed at the other registers, and through standby being set.
- R8: Outputs change only on the system clock edge that first samples ser_le high. Holding ser_le high for further cycles causes no further transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock, synchronous to clk |
| ser_dat | input | 1 | Serial data, sent most significant bit first |
| ser_le | input | 1 | Latch enable: low while shifting, a rising edge transfers the word |
| fb_main | output | 12 | Feedback divider main count |
| fb_swallow | output | 6 | Feedback divider swallow count |
| ref_count | output | 13 | Reference divider count |
| test_bits | output | 3 | Test-mode bits {R14, R15, R16} |
| standby | output | 1 | Standby request bit |
| switch_out | output | 1 | Switch-output control bit |

## Verification
The hardest state to reach from the ports is a word that was shifted while latch enable was high. The shift register has no output, so the only way to see that such bits were dropped is to cause a second transfer with no shifting in between. The stimulus does this. It clocks a full control word in with latch enable held high, then lowers and raises latch enable again. It checks that the feedback word already in the register is loaded a second time and that the standby bit stays as it was. A word with extra leading bits is also sent, to confirm that only the 20 most recent bits are used.

// File: rtl/synth_prog_pkg.sv
// Shared widths, field positions and the transfer-target type of the
// synthesizer programming port. Assumes a 20-bit word whose two least
// significant bits are the select bits.
package synth_prog_pkg;
    localparam int WORD_W    = 20;
    localparam int SEL_W     = 2;
    localparam int FB_MAIN_W = 12;
    localparam int FB_SWAL_W = 6;
    localparam int REF_W     = 13;
    localparam int TEST_W    = 3;
    localparam logic [TEST_W-1:0] TEST_RST = 3'b100;

    typedef enum logic [1:0] {
        DST_NONE = 2'd0,
        DST_FB   = 2'd1,
        DST_REF  = 2'd2,
        DST_CTL  = 2'd3
    } dest_e;
endpackage

// File: rtl/prog_rise_detect.sv
// Rising-edge detector for a group of level lines already synchronous to clk.
// Assumes each line is held for at least one clk cycle between changes.
// A rise pulse lasts one cycle, in the cycle where the new high level is
// first present on the input.
module prog_rise_detect #(
    parameter int LINES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] lvl,
    output logic [LINES-1:0] rise
);
    logic [LINES-1:0] lvl_q;

    // Store the previous level of every line.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= '0;
        else        lvl_q <= lvl;
    end

    for (genvar g = 0; g < LINES; g++) begin : g_line
        // A line rises when it is high now and was low in the cycle before.
        assign rise[g] = lvl[g] & ~lvl_q[g];

        // A rise pulse is never followed by another rise on the same line.
        assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
            rise[g] |=> !rise[g]);
    end
endmodule

// File: rtl/prog_shifter.sv
// Serial-in shift register. It takes one bit, at the least significant end,
// in every cycle where shift_en is high. Assumes the first bit sent is the
// most significant bit of the word.
module prog_shifter #(
    parameter int W = synth_prog_pkg::WORD_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         din,
    output logic [W-1:0] word
);
    // Move the word up by one bit and append the new one.
    always_ff @(posedge clk) begin
        if (!rst_n)        word <= '0;
        else if (shift_en) word <= {word[W-2:0], din};
    end

    assert_shift_in_R2: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (word[0] == $past(din)) && (word[W-1:1] == $past(word[W-2:0])));
    assert_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(word));
endmodule

// File: rtl/prog_latch_bank.sv
// Decodes the select bits of a finished word and loads one of three holding
// registers: feedback divider, reference divider with test bits, or control.
// Assumes load is a one-cycle pulse. A register not selected keeps its value.
module prog_latch_bank
    import synth_prog_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [W-1:0]         word,
    output logic [FB_MAIN_W-1:0] fb_main,
    output logic [FB_SWAL_W-1:0] fb_swallow,
    output logic [REF_W-1:0]     ref_count,
    output logic [TEST_W-1:0]    test_bits,
    output logic                 standby,
    output logic                 switch_out
);
    localparam int DATA_LSB = SEL_W;
    localparam int MAIN_LSB = DATA_LSB + FB_SWAL_W;
    localparam int REF_LSB  = DATA_LSB + TEST_W;
    localparam int PS_POS   = W - 1;
    localparam int SW_POS   = W - 2;

    dest_e dest;

    // Pick the target: bit 0 low means feedback, otherwise bit 1 chooses.
    always_comb begin
        if (!load)        dest = DST_NONE;
        else if (!word[0]) dest = DST_FB;
        else if (word[1])  dest = DST_REF;
        else               dest = DST_CTL;
    end

    // Feedback divider register: main count above swallow count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fb_main    <= '0;
            fb_swallow <= '0;
        end else if (dest == DST_FB) begin
            fb_main    <= word[MAIN_LSB +: FB_MAIN_W];
            fb_swallow <= word[DATA_LSB +: FB_SWAL_W];
        end
    end

    // Reference divider register and test bits. The top two bits are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_count <= '0;
            test_bits <= TEST_RST;
        end else if (dest == DST_REF) begin
            ref_count <= word[REF_LSB +: REF_W];
            test_bits <= word[DATA_LSB +: TEST_W];
        end
    end

    // Control register: standby and switch bits from the top of the word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            standby    <= 1'b0;
            switch_out <= 1'b0;
        end else if (dest == DST_CTL) begin
            standby    <= word[PS_POS];
            switch_out <= word[SW_POS];
        end
    end

    assert_fb_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dest != DST_FB) |=> $stable(fb_main) && $stable(fb_swallow));
    assert_ref_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dest != DST_REF) |=> $stable(ref_count) && $stable(test_bits));
    assert_ctl_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dest != DST_CTL) |=> $stable(standby) && $stable(switch_out));
    assert_fb_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !word[0]) |=> ({fb_main, fb_swallow} == $past(word[W-1:DATA_LSB])));
    assert_ref_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (load && word[1:0] == 2'b11) |=> (ref_count == $past(word[W-3:REF_LSB])));
endmodule

// File: rtl/synth_prog_port.sv
// Top of the three-wire programming port. Serial clock rises shift data in
// while latch enable is low, and a latch enable rise transfers the word to the
// holding register its select bits choose. Assumes the serial lines are already
// synchronous to clk and that each level lasts at least one clk cycle.
module synth_prog_port
    import synth_prog_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ser_clk,
    input  logic                 ser_dat,
    input  logic                 ser_le,
    output logic [FB_MAIN_W-1:0] fb_main,
    output logic [FB_SWAL_W-1:0] fb_swallow,
    output logic [REF_W-1:0]     ref_count,
    output logic [TEST_W-1:0]    test_bits,
    output logic                 standby,
    output logic                 switch_out
);
    localparam int EDGE_LINES = 2;
    localparam int IDX_SCLK   = 0;
    localparam int IDX_LE     = 1;

    logic [EDGE_LINES-1:0] rise;
    logic [WORD_W-1:0]     word;
    logic                  shift_en;
    logic                  load;

    prog_rise_detect #(.LINES(EDGE_LINES)) i_edges (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   ({ser_le, ser_clk}),
        .rise  (rise)
    );

    // Shift only while latch enable is low. Transfer on its rising edge.
    assign shift_en = rise[IDX_SCLK] & ~ser_le;
    assign load     = rise[IDX_LE];

    prog_shifter #(.W(WORD_W)) i_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .din      (ser_dat),
        .word     (word)
    );

    prog_latch_bank #(.W(WORD_W)) i_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .word       (word),
        .fb_main    (fb_main),
        .fb_swallow (fb_swallow),
        .ref_count  (ref_count),
        .test_bits  (test_bits),
        .standby    (standby),
        .switch_out (switch_out)
    );

    // While latch enable stays high, no register may change.
    assert_le_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_le && $past(ser_le)) |=> $stable({fb_main, fb_swallow, ref_count,
                                               test_bits, standby, switch_out}));
endmodule

// File: tb/test_synth_prog_port.sv
`timescale 1ns/1ps
// Bench for the programming port: a behavioural model built on a bit queue,
// compared with the outputs on every clock, plus directed checks.
module test_synth_prog_port;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_dat = 1'b0, ser_le = 1'b0;
    logic [11:0] fb_main;
    logic [5:0]  fb_swallow;
    logic [12:0] ref_count;
    logic [2:0]  test_bits;
    logic        standby, switch_out;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    synth_prog_port i_synth_prog_port (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .ser_le(ser_le), .fb_main(fb_main), .fb_swallow(fb_swallow),
        .ref_count(ref_count), .test_bits(test_bits), .standby(standby),
        .switch_out(switch_out)
    );

    // Behavioural model state.
    bit q[$];
    int m_main, m_swal, m_ref, m_test, m_ps, m_sw;
    bit m_clk_prev, m_le_prev;

    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete();
            for (int i = 0; i < 20; i++) q.push_back(1'b0);
            m_main = 0; m_swal = 0; m_ref = 0; m_test = 4; m_ps = 0; m_sw = 0;
            m_clk_prev = 0; m_le_prev = 0;
        end else begin
            if (ser_le && !m_le_prev) begin
                int w = 0;
                foreach (q[i]) w = (w << 1) | int'(q[i]);
                if ((w & 1) == 0) begin
                    m_main = (w >> 8) & 12'hFFF;
                    m_swal = (w >> 2) & 6'h3F;
                end else if ((w & 3) == 3) begin
                    m_ref  = (w >> 5) & 13'h1FFF;
                    m_test = (w >> 2) & 7;
                end else begin
                    m_ps = (w >> 19) & 1;
                    m_sw = (w >> 18) & 1;
                end
            end
            if (ser_clk && !m_clk_prev && !ser_le) begin
                q.push_back(ser_dat);
                if (q.size() > 20) void'(q.pop_front());
            end
            m_clk_prev = ser_clk;
            m_le_prev  = ser_le;
        end
    end

    // Compare all outputs with the model on every clock (R2..R8 through the model).
    always @(negedge clk) begin
        if (rst_n && !done) begin
            vectors++;
            if (int'(fb_main) != m_main || int'(fb_swallow) != m_swal ||
                int'(ref_count) != m_ref || int'(test_bits) != m_test ||
                int'(standby) != m_ps || int'(switch_out) != m_sw) begin
                errors++;
                $display("FAIL model R4/R5/R6/R7: got %h %h %h %b %b %b exp %h %h %h %b %b %b",
                         fb_main, fb_swallow, ref_count, test_bits, standby, switch_out,
                         m_main, m_swal, m_ref, m_test[2:0], m_ps, m_sw);
            end
        end
    end

    task automatic check(string req, int got, int exp);
        vectors++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bits(logic [31:0] v, int n);
        for (int i = n - 1; i >= 0; i--) begin
            ser_dat = v[i];
            ser_clk = 1'b0;
            wait_n(2);
            ser_clk = 1'b1;
            wait_n(2);
        end
        ser_clk = 1'b0;
        wait_n(2);
    endtask

    task automatic pulse_le();
        ser_le = 1'b1;
        wait_n(3);
        ser_le = 1'b0;
        wait_n(2);
    endtask

    initial begin
        wait_n(4);
        rst_n = 1'b1;
        wait_n(1);
        // R1: reset values
        check("R1 fb_main", fb_main, 0);
        check("R1 fb_swallow", fb_swallow, 0);
        check("R1 ref_count", ref_count, 0);
        check("R1 test_bits", test_bits, 3'b100);
        check("R1 standby/switch", {standby, switch_out}, 0);

        // R4: select 00, main 156, swallow 16
        send_bits({12'd156, 6'd16, 2'b00}, 20);
        ser_le = 1'b1;
        @(posedge clk); #1;
        // R8: visible right after the first edge that samples latch enable high
        check("R8 fb_main latency", fb_main, 156);
        wait_n(2); ser_le = 1'b0; wait_n(2);
        check("R4 swallow", fb_swallow, 16);

        // R4: select 10, first select bit ignored
        send_bits({12'hFFF, 6'h2A, 2'b10}, 20);
        pulse_le();
        check("R4 sel10 main", fb_main, 12'hFFF);
        check("R4 sel10 swallow", fb_swallow, 6'h2A);

        // R5: reference word, leading bits 11 discarded
        send_bits({2'b11, 13'h0ABC, 3'b011, 2'b11}, 20);
        pulse_le();
        check("R5 ref_count", ref_count, 13'h0ABC);
        check("R5 test_bits", test_bits, 3'b011);
        check("R7 fb kept over ref", fb_main, 12'hFFF);

        // R6: control word, unused bits all ones
        send_bits({1'b1, 1'b0, 16'hFFFF, 2'b01}, 20);
        pulse_le();
        check("R6 standby", standby, 1);
        check("R6 switch_out", switch_out, 0);
        check("R7 ref kept over ctl", ref_count, 13'h0ABC);
        check("R7 test kept over ctl", test_bits, 3'b011);

        // R2: 4 leading extra bits, only the last 20 count
        send_bits({4'b1111, 12'h123, 6'h05, 2'b00}, 24);
        pulse_le();
        check("R2 main", fb_main, 12'h123);
        check("R2 swallow", fb_swallow, 6'h05);
        check("R7 standby kept in standby", standby, 1);

        // R3: shifting with latch enable high is ignored; relatch gives the old word
        ser_le = 1'b1;
        wait_n(2);
        send_bits({1'b0, 1'b1, 16'h0000, 2'b01}, 20);
        ser_le = 1'b0;
        wait_n(2);
        pulse_le();
        check("R3 main", fb_main, 12'h123);
        check("R3 standby", standby, 1);
        check("R3 switch", switch_out, 0);

        // R6: control word clearing standby, setting switch
        send_bits({1'b0, 1'b1, 16'h5A5A, 2'b01}, 20);
        pulse_le();
        check("R6 standby cleared", standby, 0);
        check("R6 switch set", switch_out, 1);
        check("R7 swallow kept", fb_swallow, 6'h05);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            vectors++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule